// File: doc/BRIEF.md
# Packet Stream Beat Width Converter

This block re-packs a packet stream between a 64-bit beat and a 128-bit beat on one clock. Every beat travels with a valid/ready handshake, a byte count, an end-of-packet flag and an abort flag. Two parameters set the input and output word widths. When the output is twice as wide as the input, the block upsizes: it pairs narrow beats into wide ones and emits a short wide beat when a packet ends on an odd narrow beat. When the output is half as wide, it downsizes: each wide beat leaves as one or two narrow beats, depending on how many of its bytes are valid.

A common use is to double the beat width ahead of a clock-domain crossing. The receiving clock then only needs to run slightly faster than half the sending clock. Abort is a per-beat flag. It ends the current packet at once, on whichever beat carries it, and discards any half-assembled word.

The upsizer has two states. In `UP_EMPTY` no low half is held. In `UP_HALF` the low half is held. A plain narrow beat in `UP_EMPTY` is stored (*store_low*, to `UP_HALF`). A last or aborting beat in `UP_EMPTY` is sent straight out (*emit_single*, stays). Any beat in `UP_HALF` completes or aborts the word (*emit_pair*, back to `UP_EMPTY`). The downsizer has three states: `DN_IDLE` (empty), `DN_LO` (presenting the low half) and `DN_HI` (presenting the high half). Its transitions are *load* (`DN_IDLE`→`DN_LO`), *split* (`DN_LO`→`DN_HI` when the high half holds bytes), *reload* (`DN_LO` or `DN_HI` back to `DN_LO` when a new wide beat is taken while the last part drains) and *drain* (back to `DN_IDLE`).

Top module: `pkt_width_conv`

## Requirements
- R1: Parameter `OUT_W` = 2×`IN_W` selects upsizing and `IN_W` = 2×`OUT_W` selects downsizing. Each byte-count port is $clog2(width/8)+1 bits wide.
- R2: A byte count holds the number of valid bytes, from 1 up to the full word. A full narrow word is coded with only the top count bit set and the lower bits zero (8 = 4'b1000). An aborted beat carries count 0.
- R3: When upsizing, two narrow beats make one wide beat. The first beat lands in bits 63:0 and the second in bits 127:64. The count is 8 plus the second beat's count, and the last flag comes from the second beat.
- R4: When upsizing, a last beat arriving with no low half held leaves at once as a wide beat with last set and that beat's own count.
- R5: When downsizing, a wide beat with more than 8 valid bytes leaves as two narrow beats, low half first. The first has count 8 and last clear. The second has count minus 8 and the wide beat's last flag.
- R6: When downsizing, a wide beat with 8 or fewer valid bytes leaves as a single narrow beat with the same count and last flag.
- R7: An input beat with abort set produces exactly one output beat with abort set, last clear and count 0. It discards any half-built or unsent remainder, so the next packet starts in the low lanes.
- R8: While m_valid is high and m_ready is low, all output fields hold steady. No beat is lost or repeated under backpressure.
- R9: During and right after reset, m_valid is low and s_ready is high.
- R10: Every output beat that is neither last nor aborted is full (count equals the output word's bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | Input beat accepted this cycle when high with s_valid |
| s_data | input | IN_W | Input word, byte 0 in the low lanes |
| s_bytes | input | $clog2(IN_W/8)+1 | Input valid byte count |
| s_last | input | 1 | Input beat ends its packet |
| s_abort | input | 1 | Input beat aborts its packet |
| m_valid | output | 1 | Output beat present |
| m_ready | input | 1 | Downstream takes the output beat |
| m_data | output | OUT_W | Output word, byte 0 in the low lanes |
| m_bytes | output | $clog2(OUT_W/8)+1 | Output valid byte count |
| m_last | output | 1 | Output beat ends its packet |
| m_abort | output | 1 | Output beat aborts its packet |

## Verification
The upsizer receives an even run of narrow beats, which shows correct lane pairing and count summing. An odd run shows the short closing wide beat. The downsizer receives wide beats that are full, just over half and at most half full, which separates the split path from the single-beat path. Aborts are sent both with a low half pending and with nothing pending, and each abort is followed by a fresh packet, which shows that stale halves are discarded. Both directions are repeated with a gapped m_ready pattern, so that lost or duplicated beats show up as count or order mismatches.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic {
        UP_EMPTY,
        UP_HALF
    } up_state_e;

    typedef enum logic [1:0] {
        DN_IDLE,
        DN_LO,
        DN_HI
    } dn_state_e;

    function automatic int cnt_w(input int word_w);
        return $clog2(word_w / 8) + 1;
    endfunction

endpackage

// File: rtl/pwc_upsize.sv
module pwc_upsize
    import pwc_pkg::*;
#(
    parameter int NW  = 64,
    localparam int WW  = 2 * NW,
    localparam int NB  = NW / 8,
    localparam int NBW = cnt_w(NW),
    localparam int WBW = cnt_w(WW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    output logic           s_ready,
    input  logic [NW-1:0]  s_data,
    input  logic [NBW-1:0] s_bytes,
    input  logic           s_last,
    input  logic           s_abort,
    output logic           m_valid,
    input  logic           m_ready,
    output logic [WW-1:0]  m_data,
    output logic [WBW-1:0] m_bytes,
    output logic           m_last,
    output logic           m_abort
);

    up_state_e      state_q, state_d;
    logic [NW-1:0]  low_q;
    logic           accept, emit;
    logic [WW-1:0]  nxt_data;
    logic [WBW-1:0] nxt_bytes;
    logic           nxt_last, nxt_abort;

    assign s_ready = !m_valid || m_ready;
    assign accept  = s_valid && s_ready;
    assign emit    = accept && (state_q == UP_HALF || s_abort || s_last);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UP_EMPTY: if (accept && !s_abort && !s_last) state_d = UP_HALF;   // store_low
            UP_HALF:  if (accept)                        state_d = UP_EMPTY;  // emit_pair
            default:                                     state_d = UP_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UP_EMPTY;
        else        state_q <= state_d;
    end

    // held low half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_q <= '0;
        else if (accept && state_q == UP_EMPTY && !s_abort && !s_last)
            low_q <= s_data;
    end

    // output word being formed
    always_comb begin
        nxt_abort = s_abort;
        if (s_abort) begin
            nxt_data  = '0;
            nxt_bytes = '0;
            nxt_last  = 1'b0;
        end else if (state_q == UP_HALF) begin
            nxt_data  = {s_data, low_q};
            nxt_bytes = WBW'(NB) + WBW'(s_bytes);
            nxt_last  = s_last;
        end else begin
            nxt_data  = {{NW{1'b0}}, s_data};
            nxt_bytes = WBW'(s_bytes);
            nxt_last  = 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            m_bytes <= '0;
            m_last  <= 1'b0;
            m_abort <= 1'b0;
        end else if (emit) begin
            m_valid <= 1'b1;
            m_data  <= nxt_data;
            m_bytes <= nxt_bytes;
            m_last  <= nxt_last;
            m_abort <= nxt_abort;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pwc_downsize.sv
module pwc_downsize
    import pwc_pkg::*;
#(
    parameter int NW  = 64,
    localparam int WW  = 2 * NW,
    localparam int NB  = NW / 8,
    localparam int NBW = cnt_w(NW),
    localparam int WBW = cnt_w(WW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    output logic           s_ready,
    input  logic [WW-1:0]  s_data,
    input  logic [WBW-1:0] s_bytes,
    input  logic           s_last,
    input  logic           s_abort,
    output logic           m_valid,
    input  logic           m_ready,
    output logic [NW-1:0]  m_data,
    output logic [NBW-1:0] m_bytes,
    output logic           m_last,
    output logic           m_abort
);

    dn_state_e      state_q, state_d;
    logic [WW-1:0]  word_q;
    logic [WBW-1:0] bytes_q;
    logic           last_q, abort_q;
    logic           needs_hi, final_beat, accept;

    assign needs_hi   = !abort_q && (bytes_q > WBW'(NB));
    assign final_beat = (state_q == DN_HI) || (state_q == DN_LO && !needs_hi);
    assign s_ready    = (state_q == DN_IDLE) || (m_ready && final_beat);
    assign accept     = s_valid && s_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DN_IDLE: if (accept) state_d = DN_LO;                       // load
            DN_LO: begin
                if (m_ready) begin
                    if (needs_hi)    state_d = DN_HI;                    // split
                    else if (accept) state_d = DN_LO;                    // reload
                    else             state_d = DN_IDLE;                  // drain
                end
            end
            DN_HI: if (m_ready) state_d = accept ? DN_LO : DN_IDLE;      // reload / drain
            default: state_d = DN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DN_IDLE;
        else        state_q <= state_d;
    end

    // wide beat holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            bytes_q <= '0;
            last_q  <= 1'b0;
            abort_q <= 1'b0;
        end else if (accept) begin
            word_q  <= s_data;
            bytes_q <= s_bytes;
            last_q  <= s_last;
            abort_q <= s_abort;
        end
    end

    // outputs
    always_comb begin
        m_valid = 1'b0;
        m_data  = '0;
        m_bytes = '0;
        m_last  = 1'b0;
        m_abort = 1'b0;
        unique case (state_q)
            DN_IDLE: ;
            DN_LO: begin
                m_valid = 1'b1;
                m_data  = word_q[NW-1:0];
                m_abort = abort_q;
                if (abort_q)       m_bytes = '0;
                else if (needs_hi) m_bytes = NBW'(NB);
                else               m_bytes = bytes_q[NBW-1:0];
                m_last  = !abort_q && !needs_hi && last_q;
            end
            DN_HI: begin
                m_valid = 1'b1;
                m_data  = word_q[WW-1:NW];
                m_bytes = NBW'(bytes_q - WBW'(NB));
                m_last  = last_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pkt_width_conv.sv
module pkt_width_conv
    import pwc_pkg::*;
#(
    parameter int IN_W  = 64,
    parameter int OUT_W = 128,
    localparam int IN_BW  = cnt_w(IN_W),
    localparam int OUT_BW = cnt_w(OUT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [IN_W-1:0]   s_data,
    input  logic [IN_BW-1:0]  s_bytes,
    input  logic              s_last,
    input  logic              s_abort,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [OUT_W-1:0]  m_data,
    output logic [OUT_BW-1:0] m_bytes,
    output logic              m_last,
    output logic              m_abort
);

    generate
        if (OUT_W == 2 * IN_W) begin : g_up
            pwc_upsize #(.NW(IN_W)) u_up (
                .clk     (clk),
                .rst_n   (rst_n),
                .s_valid (s_valid),
                .s_ready (s_ready),
                .s_data  (s_data),
                .s_bytes (s_bytes),
                .s_last  (s_last),
                .s_abort (s_abort),
                .m_valid (m_valid),
                .m_ready (m_ready),
                .m_data  (m_data),
                .m_bytes (m_bytes),
                .m_last  (m_last),
                .m_abort (m_abort)
            );
        end else begin : g_dn
            pwc_downsize #(.NW(OUT_W)) u_dn (
                .clk     (clk),
                .rst_n   (rst_n),
                .s_valid (s_valid),
                .s_ready (s_ready),
                .s_data  (s_data),
                .s_bytes (s_bytes),
                .s_last  (s_last),
                .s_abort (s_abort),
                .m_valid (m_valid),
                .m_ready (m_ready),
                .m_data  (m_data),
                .m_bytes (m_bytes),
                .m_last  (m_last),
                .m_abort (m_abort)
            );
        end
    endgenerate

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 128,
    localparam int IN_BW  = $clog2(IN_W / 8) + 1,
    localparam int OUT_BW = $clog2(OUT_W / 8) + 1,
    localparam int OUT_NB = OUT_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic [IN_W-1:0]   s_data,
    input logic [IN_BW-1:0]  s_bytes,
    input logic              s_last,
    input logic              s_abort,
    input logic              m_valid,
    input logic              m_ready,
    input logic [OUT_W-1:0]  m_data,
    input logic [OUT_BW-1:0] m_bytes,
    input logic              m_last,
    input logic              m_abort
);

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |-> (!m_valid && s_ready));

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_bytes)
                                   && $stable(m_last) && $stable(m_abort)));

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_abort) |-> (m_bytes != '0 && m_bytes <= OUT_BW'(OUT_NB)));

    assert_abort_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_abort) |-> (!m_last && m_bytes == '0));

    assert_midpacket_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last && !m_abort) |-> (m_bytes == OUT_BW'(OUT_NB)));

endmodule

bind pkt_width_conv pwc_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_pwc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .s_bytes (s_bytes),
    .s_last  (s_last),
    .s_abort (s_abort),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_bytes (m_bytes),
    .m_last  (m_last),
    .m_abort (m_abort)
);

// File: tb/pkt_width_conv_bench.sv
`timescale 1ns/1ps
module pkt_width_conv_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_ready = 1'b1;
    logic bp = 1'b0;
    int   cyc = 0;
    int   vectors = 0;
    int   misc = 0;

    always #2.5 clk = ~clk;

    // upsizer side (64 -> 128)
    logic         u_s_valid = 1'b0, u_s_last = 1'b0, u_s_abort = 1'b0;
    logic [63:0]  u_s_data = '0;
    logic [3:0]   u_s_bytes = '0;
    logic         u_s_ready, u_m_valid, u_m_last, u_m_abort;
    logic [127:0] u_m_data;
    logic [4:0]   u_m_bytes;

    // downsizer side (128 -> 64)
    logic         d_s_valid = 1'b0, d_s_last = 1'b0, d_s_abort = 1'b0;
    logic [127:0] d_s_data = '0;
    logic [4:0]   d_s_bytes = '0;
    logic         d_s_ready, d_m_valid, d_m_last, d_m_abort;
    logic [63:0]  d_m_data;
    logic [3:0]   d_m_bytes;

    pkt_width_conv #(.IN_W(64), .OUT_W(128)) u_pkt_width_conv (
        .clk(clk), .rst_n(rst_n),
        .s_valid(u_s_valid), .s_ready(u_s_ready), .s_data(u_s_data),
        .s_bytes(u_s_bytes), .s_last(u_s_last), .s_abort(u_s_abort),
        .m_valid(u_m_valid), .m_ready(m_ready), .m_data(u_m_data),
        .m_bytes(u_m_bytes), .m_last(u_m_last), .m_abort(u_m_abort)
    );

    pkt_width_conv #(.IN_W(128), .OUT_W(64)) u_pkt_width_conv_dn (
        .clk(clk), .rst_n(rst_n),
        .s_valid(d_s_valid), .s_ready(d_s_ready), .s_data(d_s_data),
        .s_bytes(d_s_bytes), .s_last(d_s_last), .s_abort(d_s_abort),
        .m_valid(d_m_valid), .m_ready(m_ready), .m_data(d_m_data),
        .m_bytes(d_m_bytes), .m_last(d_m_last), .m_abort(d_m_abort)
    );

    // downstream ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        m_ready = !bp || (cyc % 3 != 0);
    end

    // captured and expected beats; index 0 = upsizer, 1 = downsizer
    logic [127:0] got_data [0:1][0:31];
    int           got_bytes[0:1][0:31];
    logic         got_last [0:1][0:31];
    logic         got_abort[0:1][0:31];
    int           got_n[0:1];
    logic [127:0] exp_data [0:1][0:31];
    int           exp_bytes[0:1][0:31];
    logic         exp_last [0:1][0:31];
    logic         exp_abort[0:1][0:31];
    int           exp_n[0:1];

    initial begin
        got_n[0] = 0; got_n[1] = 0; exp_n[0] = 0; exp_n[1] = 0;
    end

    // monitor away from the rising edge: a beat counts when valid and ready
    always @(negedge clk) begin
        if (rst_n && u_m_valid && m_ready && got_n[0] < 32) begin
            got_data[0][got_n[0]]  = u_m_data;
            got_bytes[0][got_n[0]] = int'(u_m_bytes);
            got_last[0][got_n[0]]  = u_m_last;
            got_abort[0][got_n[0]] = u_m_abort;
            got_n[0]++;
        end
        if (rst_n && d_m_valid && m_ready && got_n[1] < 32) begin
            got_data[1][got_n[1]]  = {64'd0, d_m_data};
            got_bytes[1][got_n[1]] = int'(d_m_bytes);
            got_last[1][got_n[1]]  = d_m_last;
            got_abort[1][got_n[1]] = d_m_abort;
            got_n[1]++;
        end
    end

    function automatic logic [63:0] pat(input int k);
        return {8{8'(k * 17 + 3)}};
    endfunction

    function automatic logic [127:0] bmask(input int b);
        logic [127:0] m = '0;
        for (int i = 0; i < 16; i++)
            if (i < b) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic start();
        got_n[0] = 0; got_n[1] = 0; exp_n[0] = 0; exp_n[1] = 0;
    endtask

    task automatic expect_beat(input int w, input logic [127:0] d, input int b,
                               input logic l, input logic a);
        exp_data[w][exp_n[w]]  = d;
        exp_bytes[w][exp_n[w]] = b;
        exp_last[w][exp_n[w]]  = l;
        exp_abort[w][exp_n[w]] = a;
        exp_n[w]++;
    endtask

    task automatic send_up(input logic [63:0] d, input int b, input logic l, input logic a);
        u_s_valid = 1'b1; u_s_data = d; u_s_bytes = 4'(b); u_s_last = l; u_s_abort = a;
        do @(negedge clk); while (!u_s_ready);
        @(posedge clk); #1;
        u_s_valid = 1'b0;
    endtask

    task automatic send_dn(input logic [127:0] d, input int b, input logic l, input logic a);
        d_s_valid = 1'b1; d_s_data = d; d_s_bytes = 5'(b); d_s_last = l; d_s_abort = a;
        do @(negedge clk); while (!d_s_ready);
        @(posedge clk); #1;
        d_s_valid = 1'b0;
    endtask

    task automatic check(input int w, input string tag);
        repeat (14) @(posedge clk);
        #1;
        vectors++;
        if (got_n[w] != exp_n[w]) begin
            misc++;
            $display("FAIL %s: beat count got %0d expected %0d", tag, got_n[w], exp_n[w]);
        end
        for (int i = 0; i < exp_n[w] && i < got_n[w]; i++) begin
            logic [127:0] m;
            vectors++;
            m = exp_abort[w][i] ? '0 : bmask(exp_bytes[w][i]);
            if (got_bytes[w][i] != exp_bytes[w][i] || got_last[w][i] != exp_last[w][i] ||
                got_abort[w][i] != exp_abort[w][i] ||
                (got_data[w][i] & m) != (exp_data[w][i] & m)) begin
                misc++;
                $display("FAIL %s: beat %0d got bytes=%0d last=%b abort=%b data=%h expected bytes=%0d last=%b abort=%b data=%h",
                         tag, i, got_bytes[w][i], got_last[w][i], got_abort[w][i], got_data[w][i] & m,
                         exp_bytes[w][i], exp_last[w][i], exp_abort[w][i], exp_data[w][i] & m);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        vectors++;
        if (u_m_valid !== 1'b0 || u_s_ready !== 1'b1 || d_m_valid !== 1'b0 || d_s_ready !== 1'b1) begin
            misc++;
            $display("FAIL R9/R1: reset state got up(mv=%b sr=%b) dn(mv=%b sr=%b) expected mv=0 sr=1",
                     u_m_valid, u_s_ready, d_m_valid, d_s_ready);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    // R3: even run of narrow beats pairs into wide beats
    task automatic t_up_pair();
        start();
        send_up(pat(1), 8, 0, 0); send_up(pat(2), 8, 0, 0);
        send_up(pat(3), 8, 0, 0); send_up(pat(4), 3, 1, 0);
        expect_beat(0, {pat(2), pat(1)}, 16, 0, 0);
        expect_beat(0, {pat(4), pat(3)}, 11, 1, 0);
        check(0, "R3 pair packing");
    endtask

    // R4: odd run ends with a short wide beat
    task automatic t_up_odd();
        start();
        send_up(pat(5), 8, 0, 0); send_up(pat(6), 8, 0, 0); send_up(pat(7), 5, 1, 0);
        send_up(pat(8), 2, 1, 0);
        expect_beat(0, {pat(6), pat(5)}, 16, 0, 0);
        expect_beat(0, {64'd0, pat(7)}, 5, 1, 0);
        expect_beat(0, {64'd0, pat(8)}, 2, 1, 0);
        check(0, "R4 odd tail");
    endtask

    // R7: abort with a low half pending, and with nothing pending
    task automatic t_up_abort();
        start();
        send_up(pat(9), 8, 0, 0); send_up(pat(10), 5, 1, 1);
        send_up(pat(11), 8, 1, 0);
        send_up(pat(12), 8, 0, 1);
        send_up(pat(13), 8, 0, 0); send_up(pat(14), 1, 1, 0);
        expect_beat(0, '0, 0, 0, 1);
        expect_beat(0, {64'd0, pat(11)}, 8, 1, 0);
        expect_beat(0, '0, 0, 0, 1);
        expect_beat(0, {pat(14), pat(13)}, 9, 1, 0);
        check(0, "R7 upsize abort");
    endtask

    // R8/R10: upsizer under gapped ready
    task automatic t_up_stall();
        start();
        bp = 1'b1;
        for (int k = 0; k < 7; k++) send_up(pat(20 + k), (k == 6) ? 4 : 8, k == 6, 0);
        expect_beat(0, {pat(21), pat(20)}, 16, 0, 0);
        expect_beat(0, {pat(23), pat(22)}, 16, 0, 0);
        expect_beat(0, {pat(25), pat(24)}, 16, 0, 0);
        expect_beat(0, {64'd0, pat(26)}, 4, 1, 0);
        check(0, "R8/R10 upsize stall");
        bp = 1'b0;
    endtask

    // R5/R2: wide beats split, full narrow coded 4'b1000
    task automatic t_dn_split();
        start();
        send_dn({pat(31), pat(30)}, 16, 0, 0);
        send_dn({pat(33), pat(32)}, 12, 1, 0);
        expect_beat(1, {64'd0, pat(30)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(31)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(32)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(33)}, 4, 1, 0);
        check(1, "R5/R2 split");
    endtask

    // R6: short wide beats give one narrow beat
    task automatic t_dn_short();
        start();
        send_dn({pat(35), pat(34)}, 7, 1, 0);
        send_dn({pat(37), pat(36)}, 8, 1, 0);
        send_dn({pat(39), pat(38)}, 9, 1, 0);
        expect_beat(1, {64'd0, pat(34)}, 7, 1, 0);
        expect_beat(1, {64'd0, pat(36)}, 8, 1, 0);
        expect_beat(1, {64'd0, pat(38)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(39)}, 1, 1, 0);
        check(1, "R6 short beat");
    endtask

    // R7: downsizer abort, then a fresh packet
    task automatic t_dn_abort();
        start();
        send_dn({pat(41), pat(40)}, 16, 0, 0);
        send_dn({pat(43), pat(42)}, 16, 1, 1);
        send_dn({pat(45), pat(44)}, 3, 1, 0);
        expect_beat(1, {64'd0, pat(40)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(41)}, 8, 0, 0);
        expect_beat(1, '0, 0, 0, 1);
        expect_beat(1, {64'd0, pat(44)}, 3, 1, 0);
        check(1, "R7 downsize abort");
    endtask

    // R8: downsizer under gapped ready
    task automatic t_dn_stall();
        start();
        bp = 1'b1;
        send_dn({pat(51), pat(50)}, 16, 0, 0);
        send_dn({pat(53), pat(52)}, 16, 0, 0);
        send_dn({pat(55), pat(54)}, 5, 1, 0);
        expect_beat(1, {64'd0, pat(50)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(51)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(52)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(53)}, 8, 0, 0);
        expect_beat(1, {64'd0, pat(54)}, 5, 1, 0);
        check(1, "R8 downsize stall");
        bp = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misc++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_up_pair();
        t_up_odd();
        t_up_abort();
        t_up_stall();
        t_dn_split();
        t_dn_short();
        t_dn_abort();
        t_dn_stall();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
        $finish;
    end

endmodule